// File: doc/BRIEF.md
# Masked Vector Expand Unit

This unit spreads packed 64-bit elements from a source vector into the destination lanes picked by an 8-bit lane mask. Source elements are taken in order, starting from the lowest one. Each selected destination lane receives the next unused element. Lanes that are not selected either keep the old destination value or are cleared, depending on a mode input. The vector may be 128, 256 or 512 bits wide, and all result bits above the active width are cleared.

The unit also checks the 4-bit extra-register specifier of the instruction, which is reserved for this operation. When the specifier is illegal, the unit still produces a result but marks it with an error-qualified valid instead of the normal valid. It also outputs the memory-form displacement scaled by one element size.

The unit accepts one operation per cycle. All outputs appear one cycle after acceptance, through a single register stage.

Top module: `vexpand_unit`

## Requirements
- R1: `vl_sel` sets the active lane count: 2'b00 gives 2 lanes (128 bits), 2'b01 gives 4 lanes (256 bits), and 2'b10 or 2'b11 gives 8 lanes (512 bits). Lane j occupies bits [64j+63:64j].
- R2: Each selected destination lane j receives source element p, where p is the number of selected lanes below j. Source elements are therefore consumed from lane 0 upward.
- R3: When `zero_mode` is 0, an unselected active lane holds the value of the same lane of `old_dst`.
- R4: When `zero_mode` is 1, an unselected active lane is zero.
- R5: When `mask_en` is 0, every active lane is selected, so the active part of the result equals the low lanes of `src`.
- R6: Result bits from 64 times the active lane count up to bit 511 are zero, in every mode.
- R7: Mask bits at or above the active lane count have no effect on the result.
- R8: When `reg_spec` is not 4'b1111, the unit asserts `out_err_valid` and `illegal` instead of `out_valid`. The result is still computed as for a legal operation. When `reg_spec` is 4'b1111, `illegal` is 0.
- R9: `disp_scaled` is the signed 8-bit `disp8` multiplied by 8, as an 11-bit signed value.
- R10: An operation accepted with `in_valid` produces its outputs, together with exactly one of `out_valid` or `out_err_valid`, on the next clock edge. One operation is accepted per cycle. A cycle without `in_valid` gives no valid on the next cycle, and synchronous active-high `rst` clears both valids.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 512 | Packed source elements |
| old_dst | input | 512 | Previous destination value used for merging |
| kmask | input | 8 | Lane selection mask |
| mask_en | input | 1 | 1: apply `kmask`; 0: select all active lanes |
| zero_mode | input | 1 | 1: clear unselected lanes; 0: keep old value |
| vl_sel | input | 2 | Vector length select |
| reg_spec | input | 4 | Reserved register specifier; must be 4'b1111 |
| disp8 | input | 8 | Signed compressed displacement |
| out_valid | output | 1 | Legal result available |
| out_err_valid | output | 1 | Result available but illegal |
| illegal | output | 1 | Registered illegal-specifier flag |
| result | output | 512 | Expanded vector |
| disp_scaled | output | 11 | Displacement multiplied by 8 |

## Verification
The hardest cases to reach from the ports are lanes whose source index depends on the sparse mask bits below them. Partially set masks are the main example. So are masks whose set bits lie above the active lane count and must leave the result unchanged. The bench reaches every such pattern by sweeping all 256 mask values, for each vector length, masking mode and zeroing mode, with a different source and old-destination pattern for each operation. It checks the result against a lane-by-lane model. Separate sweeps cover all 16 specifier values and all 256 displacements.

// File: rtl/vexpand_unit.sv
module vexpand_unit #(
  parameter int EW    = 64,
  parameter int LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [EW*LANES-1:0]    src,
  input  logic [EW*LANES-1:0]    old_dst,
  input  logic [LANES-1:0]       kmask,
  input  logic                   mask_en,
  input  logic                   zero_mode,
  input  logic [1:0]             vl_sel,
  input  logic [3:0]             reg_spec,
  input  logic [7:0]             disp8,
  output logic                   out_valid,
  output logic                   out_err_valid,
  output logic                   illegal,
  output logic [EW*LANES-1:0]    result,
  output logic [10:0]            disp_scaled
);
  localparam int IW = $clog2(LANES) + 1;

  logic [IW-1:0]       n_act;
  logic [LANES-1:0]    act, sel;
  logic [EW*LANES-1:0] nxt;
  logic                bad;

  assign n_act = (vl_sel == 2'b00) ? IW'(2) : (vl_sel == 2'b01) ? IW'(4) : IW'(LANES);
  assign bad   = (reg_spec != 4'b1111);

  function automatic logic [IW-1:0] ones_below(input logic [LANES-1:0] m, input int j);
    logic [IW-1:0] c;
    c = '0;
    for (int i = 0; i < LANES; i++)
      if (i < j && m[i]) c = c + IW'(1);
    return c;
  endfunction

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IW-1:0] pick;
    assign act[j] = (IW'(j) < n_act);
    assign sel[j] = act[j] & (mask_en ? kmask[j] : 1'b1);
    assign pick   = ones_below(sel, j);
    always_comb begin
      if (sel[j])
        nxt[j*EW +: EW] = src[pick[IW-2:0]*EW +: EW];
      else if (act[j] && !zero_mode)
        nxt[j*EW +: EW] = old_dst[j*EW +: EW];
      else
        nxt[j*EW +: EW] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_err_valid <= 1'b0;
    end else begin
      out_valid     <= in_valid & ~bad;
      out_err_valid <= in_valid & bad;
    end
    if (in_valid) begin
      result      <= nxt;
      illegal     <= bad;
      disp_scaled <= {disp8, 3'b000};
    end
  end
endmodule

module vexpand_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [511:0] src,
  input logic         mask_en,
  input logic [1:0]   vl_sel,
  input logic [3:0]   reg_spec,
  input logic [7:0]   disp8,
  input logic         out_valid,
  input logic         out_err_valid,
  input logic         illegal,
  input logic [511:0] result,
  input logic [10:0]  disp_scaled
);
  assert_one_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_err_valid));
  assert_legal_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && reg_spec == 4'b1111) |=> (out_valid && !illegal));
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_err_valid));
  assert_err_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && reg_spec != 4'b1111) |=> (out_err_valid && illegal && !out_valid));
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vl_sel == 2'b00) |=> (result[511:128] == '0));
  assert_nomask_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mask_en && vl_sel[1]) |=> (result == $past(src)));
  assert_disp_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ($signed(disp_scaled) == $signed($past(disp8)) * 11'sd8));
endmodule

bind vexpand_unit vexpand_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .mask_en(mask_en),
  .vl_sel(vl_sel), .reg_spec(reg_spec), .disp8(disp8), .out_valid(out_valid),
  .out_err_valid(out_err_valid), .illegal(illegal), .result(result),
  .disp_scaled(disp_scaled)
);

// File: tb/vexpand_unit_bench.sv
`timescale 1ns/1ps
module vexpand_unit_bench;
  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic [511:0] src = '0, old_dst = '0;
  logic [7:0]   kmask = '0;
  logic         mask_en = 0, zero_mode = 0;
  logic [1:0]   vl_sel = '0;
  logic [3:0]   reg_spec = 4'hF;
  logic [7:0]   disp8 = '0;
  logic         out_valid, out_err_valid, illegal;
  logic [511:0] result;
  logic [10:0]  disp_scaled;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vexpand_unit u_vexpand_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .kmask(kmask), .mask_en(mask_en), .zero_mode(zero_mode), .vl_sel(vl_sel),
    .reg_spec(reg_spec), .disp8(disp8), .out_valid(out_valid),
    .out_err_valid(out_err_valid), .illegal(illegal), .result(result),
    .disp_scaled(disp_scaled)
  );

  function automatic logic [511:0] model(input logic [511:0] s, input logic [511:0] o,
      input logic [7:0] k, input logic men, input logic z, input logic [1:0] vl);
    logic [511:0] r;
    int n, p;
    r = '0;
    p = 0;
    n = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
    for (int j = 0; j < n; j++) begin
      if (!men || k[j]) begin
        r[j*64 +: 64] = s[p*64 +: 64];
        p++;
      end else if (!z) begin
        r[j*64 +: 64] = o[j*64 +: 64];
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input int tag);
    @(negedge clk);
    in_valid = 1;
    for (int e = 0; e < 8; e++) begin
      src[e*64 +: 64]     = {16'h5A00 | 16'(e), 16'(tag), 32'(tag * 7 + e)};
      old_dst[e*64 +: 64] = {16'hC300 | 16'(e), 16'(tag), 32'(~(tag + e))};
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] exp;
    int tag;
    tag = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !out_err_valid, "R10 reset", {510'b0, out_valid, out_err_valid}, '0);
    rst = 0;

    // R1 R2 R3 R4 R5 R6 R7: full mask sweep
    for (int v = 0; v < 4; v++)
      for (int me = 0; me < 2; me++)
        for (int z = 0; z < 2; z++)
          for (int k = 0; k < 256; k++) begin
            vl_sel = 2'(v); mask_en = me[0]; zero_mode = z[0]; kmask = 8'(k);
            reg_spec = 4'hF; disp8 = 8'(k);
            tag++;
            issue(tag);
            exp = model(src, old_dst, kmask, mask_en, zero_mode, vl_sel);
            check(result == exp, "R1 R2 R3 R4 R5 R6 R7 result", result, exp);
            check(out_valid && !out_err_valid && !illegal, "R10 legal valid",
                  {509'b0, out_valid, out_err_valid, illegal}, 512'b100);
          end

    // R8: specifier sweep
    for (int s = 0; s < 16; s++) begin
      vl_sel = 2'b10; mask_en = 1; zero_mode = 0; kmask = 8'hA5; reg_spec = 4'(s);
      tag++;
      issue(tag);
      exp = model(src, old_dst, kmask, mask_en, zero_mode, vl_sel);
      check(result == exp, "R8 result kept", result, exp);
      if (s == 15)
        check(out_valid && !out_err_valid && !illegal, "R8 legal spec",
              {509'b0, out_valid, out_err_valid, illegal}, 512'b100);
      else
        check(!out_valid && out_err_valid && illegal, "R8 illegal spec",
              {509'b0, out_valid, out_err_valid, illegal}, 512'b011);
    end

    // R9: displacement sweep
    reg_spec = 4'hF;
    for (int d = 0; d < 256; d++) begin
      disp8 = 8'(d);
      tag++;
      issue(tag);
      check($signed(disp_scaled) == 11'($signed(8'(d)) * 8), "R9 disp",
            {501'b0, disp_scaled}, {501'b0, 11'($signed(8'(d)) * 8)});
    end

    // R10: idle cycle and reset during traffic
    @(negedge clk);
    in_valid = 0;
    @(posedge clk); #1;
    check(!out_valid && !out_err_valid, "R10 idle", {510'b0, out_valid, out_err_valid}, '0);
    @(negedge clk);
    in_valid = 1; rst = 1;
    @(posedge clk); #1;
    check(!out_valid && !out_err_valid, "R10 reset clears", {510'b0, out_valid, out_err_valid}, '0);
    @(negedge clk);
    rst = 0; in_valid = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule